// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Receiver

This block takes characters from one asynchronous serial line that idles high. A high-to-low change on the line marks the start of a frame. The block times each bit from a clock-enable tick that runs at sixteen times the bit rate. It assembles 7 or 8 data bits, least significant bit first. When parity is enabled it checks one parity bit, even or odd. It then checks the stop bit. The framing is set at run time: data length, parity mode and one or two stop bits. The line comes from one of two pin sets, picked by a select input that is set before traffic starts.

A finished character moves into a holding register. The next character can then shift in while software still holds the previous one. A ready flag marks that the holding register has something new. Parity and framing error flags travel with the character they belong to. A sticky overrun flag records that a later character was thrown away because the held one had not been read. One read strobe clears the ready flag and all three error flags.

Top module: `serial_rx_dbuf`

## Requirements
- R1: After reset, rx_ready, err_parity, err_frame and err_overrun are 0 and rx_data is 0x00.
- R2: With pin_sel=0 the receiver listens only to line_a. With pin_sel=1 it listens only to line_b. Activity on the other line has no effect.
- R3: A low level seen on a tick is checked again 8 ticks later. If the line is high by then, the event is dropped as a glitch and no character is produced.
- R4: With cfg_eight=1, eight data bits are taken least significant bit first and appear as rx_data[7:0].
- R5: With cfg_eight=0, seven data bits are taken least significant bit first and appear in rx_data[6:0], with rx_data[7]=0.
- R6: With cfg_par_en=1, one parity bit follows the data. cfg_par_odd=0 selects even parity and 1 selects odd parity. When the count of ones over the data bits plus the parity bit does not match the selected sense, err_parity is set together with the character.
- R7: With cfg_par_en=0, no parity bit is expected. The bit after the data is the stop bit, and err_parity stays 0.
- R8: A low level at the first stop-bit sample sets err_frame together with the character. The receiver then waits for the line to go high before it looks for a new start.
- R9: With cfg_two_stop=1, the receiver waits through a second stop-bit period but does not check it. A low second stop bit causes no error.
- R10: A completed character sets rx_ready. rx_data stays unchanged while rx_ready is set. A one-cycle rd_stb clears rx_ready, err_parity, err_frame and err_overrun. If a read and a completion fall in the same cycle, the new character is taken.
- R11: If a character completes while rx_ready is set and no read occurs in that cycle, the character is discarded, the held data is kept, and err_overrun is set. err_overrun stays set until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_a | input | 1 | Serial input, pin set 0 |
| line_b | input | 1 | Serial input, pin set 1 |
| pin_sel | input | 1 | Picks the pin set: 0 selects line_a, 1 selects line_b |
| tick16 | input | 1 | One-cycle enable at 16 times the bit rate |
| cfg_eight | input | 1 | 1 selects 8 data bits, 0 selects 7 |
| cfg_par_en | input | 1 | 1 means a parity bit is present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| rd_stb | input | 1 | Read strobe that clears ready and the error flags |
| rx_data | output | 8 | Held character |
| rx_ready | output | 1 | The holding register has an unread character |
| err_parity | output | 1 | Parity error for the held character |
| err_frame | output | 1 | Stop-bit error for the held character |
| err_overrun | output | 1 | A character was lost while the held one was unread (sticky) |

## Verification
The checker watches the holding-register rules on every cycle:
- a read without a completion empties the register and clears all flags;
- the held data does not move while it waits to be read;
- a completion into a full register raises overrun;
- no error flag is set without rx_ready;
- ready rises only on a completion.

Only the bench scenarios show the serial side: bit order for 7 and 8 data bits, parity in both senses, framing and the wait for a high line, the unchecked second stop bit, glitch rejection, and that the unselected pin is ignored.

// File: rtl/serial_rx_pkg.sv
// Shared types for the asynchronous serial receiver.
// Assumes nothing beyond the standard language; holds the frame sequencer states.
package serial_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE   = 3'd0,
        RX_START  = 3'd1,
        RX_DATA   = 3'd2,
        RX_PARITY = 3'd3,
        RX_STOP1  = 3'd4,
        RX_STOP2  = 3'd5,
        RX_BREAK  = 3'd6
    } rx_state_t;

    typedef struct packed {
        logic long_char;
        logic par_en;
        logic par_odd;
        logic two_stop;
    } rx_cfg_t;

endpackage

// File: rtl/rx_line_front.sv
// Picks one of the two serial input pin sets and brings the chosen level into the
// clock domain through a chain of flip-flops.
// Assumes the select input only changes while the line is idle; the chain resets
// to the idle (high) level so that reset is never seen as a start bit.
module rx_line_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_a,
    input  logic line_b,
    input  logic pin_sel,
    output logic line_sync
);

    logic             raw_line;
    logic [SYNC_STAGES-1:0] chain_q;

    // Pin set multiplexer ahead of the synchroniser.
    always_comb begin
        raw_line = pin_sel ? line_b : line_a;
    end

    genvar gi;
    generate
        for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
            if (gi == 0) begin : g_first
                // First stage captures the asynchronous level.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= raw_line;
                end
            end else begin : g_next
                // Later stages settle the captured level.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[gi] <= 1'b1;
                    else        chain_q[gi] <= chain_q[gi-1];
                end
            end
        end
    endgenerate

    assign line_sync = chain_q[SYNC_STAGES-1];

endmodule

// File: rtl/rx_frame_fsm.sv
// Frame sequencer: finds a start bit, re-checks it at mid-bit, then samples each
// later bit at its midpoint (OSR ticks apart). It assembles data LSB first, checks
// parity and the first stop bit, and pulses done for one cycle with the character.
// Assumes tick is a one-cycle enable at OSR times the bit rate and line is synchronous.
// Framing options are latched when the start bit is confirmed.
module rx_frame_fsm
    import serial_rx_pkg::*;
#(
    parameter int OSR    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line,
    input  rx_cfg_t           cfg,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              perr,
    output logic              ferr
);

    localparam int CW = $clog2(OSR);
    localparam int BW = $clog2(DATA_W + 1);
    localparam logic [CW-1:0] CNT_LAST  = CW'(OSR - 1);
    localparam logic [CW-1:0] CNT_HALF  = CW'(OSR / 2);
    localparam logic [BW-1:0] IDX_LONG  = BW'(DATA_W - 1);
    localparam logic [BW-1:0] IDX_SHORT = BW'(DATA_W - 2);

    rx_state_t         state_q;
    logic [CW-1:0]     cnt_q;
    logic [BW-1:0]     bit_q;
    logic [DATA_W-1:0] shift_q;
    logic              acc_q;
    logic              pe_q;
    rx_cfg_t           lcfg_q;
    logic              sample;
    logic [BW-1:0]     last_idx;
    logic [DATA_W-1:0] aligned;

    // Mid-bit sampling point and the index of the last data bit.
    always_comb begin
        sample   = tick && (cnt_q == CNT_LAST);
        last_idx = lcfg_q.long_char ? IDX_LONG : IDX_SHORT;
        aligned  = lcfg_q.long_char ? shift_q : {1'b0, shift_q[DATA_W-1:1]};
    end

    // Oversampling counter: preset at a start edge, otherwise advances on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (state_q == RX_IDLE && !line) cnt_q <= CNT_HALF;
            else                             cnt_q <= cnt_q + 1'b1;
        end
    end

    // Frame state sequence and data/parity assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            bit_q   <= '0;
            shift_q <= '0;
            acc_q   <= 1'b0;
            pe_q    <= 1'b0;
            lcfg_q  <= '0;
        end else begin
            case (state_q)
                RX_IDLE: begin
                    if (tick && !line) state_q <= RX_START;
                end
                RX_START: begin
                    if (sample) begin
                        if (line) begin
                            state_q <= RX_IDLE;
                        end else begin
                            state_q <= RX_DATA;
                            bit_q   <= '0;
                            shift_q <= '0;
                            acc_q   <= 1'b0;
                            pe_q    <= 1'b0;
                            lcfg_q  <= cfg;
                        end
                    end
                end
                RX_DATA: begin
                    if (sample) begin
                        shift_q <= {line, shift_q[DATA_W-1:1]};
                        acc_q   <= acc_q ^ line;
                        bit_q   <= bit_q + 1'b1;
                        if (bit_q == last_idx)
                            state_q <= lcfg_q.par_en ? RX_PARITY : RX_STOP1;
                    end
                end
                RX_PARITY: begin
                    if (sample) begin
                        pe_q    <= acc_q ^ line ^ lcfg_q.par_odd;
                        state_q <= RX_STOP1;
                    end
                end
                RX_STOP1: begin
                    if (sample) begin
                        if (!line)                state_q <= RX_BREAK;
                        else if (lcfg_q.two_stop) state_q <= RX_STOP2;
                        else                      state_q <= RX_IDLE;
                    end
                end
                RX_STOP2: begin
                    if (sample) state_q <= RX_IDLE;
                end
                RX_BREAK: begin
                    if (tick && line) state_q <= RX_IDLE;
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    // Character hand-off: one-cycle done with data and error bits at the stop sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            data <= '0;
            perr <= 1'b0;
            ferr <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state_q == RX_STOP1 && sample) begin
                done <= 1'b1;
                data <= aligned;
                perr <= lcfg_q.par_en & pe_q;
                ferr <= ~line;
            end
        end
    end

endmodule

// File: rtl/rx_hold_buf.sv
// Second buffer stage: keeps the last character for software together with its
// parity and framing flags, a ready flag and a sticky overrun flag.
// Assumes done is a one-cycle pulse; a read in the same cycle as done lets the new
// character in.
module rx_hold_buf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] din,
    input  logic              perr_in,
    input  logic              ferr_in,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] dout,
    output logic              ready,
    output logic              perr,
    output logic              ferr,
    output logic              ovr
);

    logic accept;

    // A character is taken when the register is empty or is being read now.
    always_comb begin
        accept = done && (!ready || rd_stb);
    end

    // Holding register, per-character flags and overrun tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout  <= '0;
            ready <= 1'b0;
            perr  <= 1'b0;
            ferr  <= 1'b0;
            ovr   <= 1'b0;
        end else begin
            if (rd_stb) begin
                ready <= 1'b0;
                perr  <= 1'b0;
                ferr  <= 1'b0;
                ovr   <= 1'b0;
            end
            if (accept) begin
                dout  <= din;
                ready <= 1'b1;
                perr  <= perr_in;
                ferr  <= ferr_in;
            end else if (done) begin
                ovr <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/serial_rx_dbuf.sv
// Top of the double-buffered asynchronous receiver: pin selection and sync,
// frame sequencer, and holding register.
// Assumes tick16 is supplied by an external baud source and that pin_sel only
// changes while the line is idle.
module serial_rx_dbuf
    import serial_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_a,
    input  logic              line_b,
    input  logic              pin_sel,
    input  logic              tick16,
    input  logic              cfg_eight,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              err_parity,
    output logic              err_frame,
    output logic              err_overrun
);

    logic              line_sync;
    rx_cfg_t           frame_cfg;
    logic              frm_done;
    logic [DATA_W-1:0] frm_data;
    logic              frm_perr;
    logic              frm_ferr;

    // Bundle the framing inputs for the sequencer.
    always_comb begin
        frame_cfg.long_char = cfg_eight;
        frame_cfg.par_en    = cfg_par_en;
        frame_cfg.par_odd   = cfg_par_odd;
        frame_cfg.two_stop  = cfg_two_stop;
    end

    rx_line_front #(.SYNC_STAGES(SYNC_STAGES)) front_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_a    (line_a),
        .line_b    (line_b),
        .pin_sel   (pin_sel),
        .line_sync (line_sync)
    );

    rx_frame_fsm #(.OSR(OSR), .DATA_W(DATA_W)) fsm_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick16),
        .line  (line_sync),
        .cfg   (frame_cfg),
        .done  (frm_done),
        .data  (frm_data),
        .perr  (frm_perr),
        .ferr  (frm_ferr)
    );

    rx_hold_buf #(.DATA_W(DATA_W)) hold_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .done    (frm_done),
        .din     (frm_data),
        .perr_in (frm_perr),
        .ferr_in (frm_ferr),
        .rd_stb  (rd_stb),
        .dout    (rx_data),
        .ready   (rx_ready),
        .perr    (err_parity),
        .ferr    (err_frame),
        .ovr     (err_overrun)
    );

endmodule

// File: rtl/serial_rx_dbuf_chk.sv
// Checker for the holding-register rules of the receiver, bound into the top.
// Assumes it sees the internal completion pulse frm_done of the top module.
module serial_rx_dbuf_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_stb,
    input logic              frm_done,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_ready,
    input logic              err_parity,
    input logic              err_frame,
    input logic              err_overrun
);

    // R10
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !frm_done) |=> (!rx_ready && !err_parity && !err_frame && !err_overrun));

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && !rd_stb) |=> $stable(rx_data));

    // R10
    ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> $past(frm_done));

    // R11
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && frm_done && !rd_stb) |=> (err_overrun && rx_ready));

    // R11
    flag_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_overrun || err_parity || err_frame) |-> rx_ready);

endmodule

bind serial_rx_dbuf serial_rx_dbuf_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/serial_rx_dbuf_tb.sv
// Directed bench for the double-buffered serial receiver: one task per scenario.
module serial_rx_dbuf_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int BIT_CLKS   = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_a = 1'b1;
    logic       line_b = 1'b1;
    logic       pin_sel = 1'b0;
    logic       tick16 = 1'b0;
    logic       cfg_eight = 1'b1;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready;
    logic       err_parity;
    logic       err_frame;
    logic       err_overrun;

    int checks = 0;
    int errors = 0;
    int tdiv = 0;
    bit use_b = 1'b0;

    serial_rx_dbuf dut_i (
        .clk(clk), .rst_n(rst_n), .line_a(line_a), .line_b(line_b),
        .pin_sel(pin_sel), .tick16(tick16), .cfg_eight(cfg_eight),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .rd_stb(rd_stb), .rx_data(rx_data),
        .rx_ready(rx_ready), .err_parity(err_parity), .err_frame(err_frame),
        .err_overrun(err_overrun)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Oversampling tick, changed away from the active edge.
    always @(negedge clk) begin
        tdiv   <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        tick16 <= (tdiv == TICK_DIV - 1);
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put_line(input logic v, input int n);
        if (use_b) line_b = v;
        else       line_a = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input bit eight, input bit pen,
                        input bit podd, input bit badp, input bit stop_low,
                        input bit two, input bit s2_low);
        logic [7:0] dm;
        @(negedge clk);
        cfg_eight = eight; cfg_par_en = pen; cfg_par_odd = podd; cfg_two_stop = two;
        dm = eight ? d : {1'b0, d[6:0]};
        put_line(1'b0, BIT_CLKS);
        for (int i = 0; i < (eight ? 8 : 7); i++) put_line(d[i], BIT_CLKS);
        if (pen) put_line((^dm) ^ podd ^ badp, BIT_CLKS);
        put_line(!stop_low, BIT_CLKS);
        if (two) begin
            if (s2_low) begin
                put_line(1'b0, 40);
                put_line(1'b1, BIT_CLKS - 40);
            end else begin
                put_line(1'b1, BIT_CLKS);
            end
        end
        put_line(1'b1, 2 * BIT_CLKS);
    endtask

    task automatic do_read();
        @(negedge clk); rd_stb = 1'b1;
        @(negedge clk); rd_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 ready", {7'd0, rx_ready}, 8'h00);
        chk("R1 perr", {7'd0, err_parity}, 8'h00);
        chk("R1 ferr", {7'd0, err_frame}, 8'h00);
        chk("R1 ovr", {7'd0, err_overrun}, 8'h00);
        chk("R1 data", rx_data, 8'h00);
    endtask

    task automatic t_basic8();
        send(8'hA5, 1, 0, 0, 0, 0, 0, 0);
        chk("R4 ready", {7'd0, rx_ready}, 8'h01);
        chk("R4 data", rx_data, 8'hA5);
        chk("R7 no parity err", {7'd0, err_parity}, 8'h00);
        do_read();
        chk("R10 read clears ready", {7'd0, rx_ready}, 8'h00);
        send(8'h3C, 1, 0, 0, 0, 0, 0, 0);
        chk("R4 data 2", rx_data, 8'h3C);
        do_read();
    endtask

    task automatic t_seven();
        send(8'hD3, 0, 0, 0, 0, 0, 0, 0);
        chk("R5 data 7-bit", rx_data, 8'h53);
        do_read();
    endtask

    task automatic t_parity();
        send(8'h6B, 1, 1, 0, 0, 0, 0, 0);
        chk("R6 even good", {err_parity, rx_data[6:0]}, {1'b0, 7'h6B});
        do_read();
        send(8'h6B, 1, 1, 1, 1, 0, 0, 0);
        chk("R6 odd bad", {7'd0, err_parity}, 8'h01);
        chk("R6 odd bad data", rx_data, 8'h6B);
        do_read();
        chk("R10 read clears perr", {7'd0, err_parity}, 8'h00);
        send(8'h2A, 0, 1, 1, 0, 0, 0, 0);
        chk("R6 7-bit odd good", {err_parity, rx_data[6:0]}, {1'b0, 7'h2A});
        do_read();
    endtask

    task automatic t_framing();
        send(8'h81, 1, 0, 0, 0, 1, 0, 0);
        chk("R8 ferr", {7'd0, err_frame}, 8'h01);
        chk("R8 data", rx_data, 8'h81);
        do_read();
        chk("R8 no extra char", {7'd0, rx_ready}, 8'h00);
        send(8'h5A, 1, 0, 0, 0, 0, 0, 0);
        chk("R8 recovers", {err_frame, rx_data[6:0]}, {1'b0, 7'h5A});
        do_read();
    endtask

    task automatic t_two_stop();
        send(8'hC7, 1, 1, 0, 0, 0, 1, 1);
        chk("R9 no ferr", {7'd0, err_frame}, 8'h00);
        chk("R9 data", rx_data, 8'hC7);
        do_read();
        chk("R9 no extra char", {7'd0, rx_ready}, 8'h00);
    endtask

    task automatic t_glitch();
        put_line(1'b0, 3 * TICK_DIV);
        put_line(1'b1, 3 * BIT_CLKS);
        chk("R3 glitch rejected", {7'd0, rx_ready}, 8'h00);
    endtask

    task automatic t_pinsel();
        pin_sel = 1'b1;
        use_b   = 1'b0;
        send(8'h00, 1, 0, 0, 0, 0, 0, 0);
        chk("R2 line_a ignored", {7'd0, rx_ready}, 8'h00);
        use_b = 1'b1;
        send(8'h96, 1, 0, 0, 0, 0, 0, 0);
        chk("R2 line_b data", rx_data, 8'h96);
        chk("R2 line_b ready", {7'd0, rx_ready}, 8'h01);
        do_read();
        use_b   = 1'b0;
        pin_sel = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic t_overrun();
        send(8'h11, 1, 0, 0, 0, 0, 0, 0);
        send(8'h22, 1, 0, 0, 0, 0, 0, 0);
        chk("R11 held data kept", rx_data, 8'h11);
        chk("R11 overrun set", {7'd0, err_overrun}, 8'h01);
        send(8'h33, 1, 0, 0, 0, 0, 0, 0);
        chk("R11 overrun sticky", {err_overrun, rx_data[6:0]}, {1'b1, 7'h11});
        do_read();
        chk("R10 read clears ovr", {rx_ready, err_overrun}, 8'h00);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_basic8();
        t_seven();
        t_parity();
        t_framing();
        t_two_stop();
        t_glitch();
        t_pinsel();
        t_overrun();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule